// File: doc/BRIEF.md
# CAN Error-State Interrupt Flags

This block holds the error-related interrupt flags of a CAN controller. It watches the receive and transmit error counters and raises a flag when either counter first enters the error-passive band. It raises a separate flag when the transmit counter first passes 255, which is bus-off, and another flag on any data-overrun pulse. Each flag stays set until the CPU clears it by writing a one to its bit. Every flag whose mask bit is zero feeds a single combined error interrupt.

The bus-off flag has a recovery lock. A monitor counts recessive bus samples, one per sample strobe. Every unbroken run of 11 recessive samples adds one to a run counter. A dominant sample restarts the current run. The CPU cannot clear bus-off until the run counter has reached 128. The run counter restarts whenever bus-off is newly entered. While bus-off is set, the error-passive flags do not set. A soft-reset bit holds every flag cleared.

Top module: `canErrFlags`

## Requirements
- R1: The receive-passive flag (flags[3]) sets on the first cycle that rxErrCnt is at least 128, unless the bus-off flag is set.
- R2: The transmit-passive flag (flags[2]) sets on the first cycle that txErrCnt lies in 128..255, unless the bus-off flag is set.
- R3: The bus-off flag (flags[1]) sets on the first cycle that txErrCnt exceeds 255.
- R4: While flags[1] is set, entering either passive band does not set flags[2] or flags[3].
- R5: A write-one-to-clear of flags[1] has no effect until 128 runs of 11 consecutive recessive samples have been counted. A sample is taken when sampleStb=1, and busLevel=1 means recessive. A dominant sample restarts the current run.
- R6: When bus-off is newly entered, the run count restarts at zero, so a later clear of flags[1] is blocked again.
- R7: The overrun flag (flags[0]) sets in any cycle that overrunEvt is 1.
- R8: clrWe=1 clears every flag whose clrBits bit is 1. A set event in the same cycle wins over the clear. A condition that merely persists does not set its flag again.
- R9: errIrq is 1 exactly when some flags bit is 1 and the matching maskBits bit is 0.
- R10: While softRst is 1, all flags are cleared on each clock and no event sets them.
- R11: After the asynchronous reset, flags is 0 and errIrq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| softRst | input | 1 | Holds all flags and the run count cleared |
| rxErrCnt | input | 8 | Receive error counter value |
| txErrCnt | input | 9 | Transmit error counter value |
| busLevel | input | 1 | Sampled bus level, 1 = recessive |
| sampleStb | input | 1 | Marks a valid busLevel sample |
| overrunEvt | input | 1 | Data overrun event pulse |
| maskBits | input | 4 | Per-flag interrupt mask, 1 = masked |
| clrWe | input | 1 | CPU clear strobe |
| clrBits | input | 4 | Bits to clear when clrWe is 1 |
| flags | output | 4 | [3] rx passive, [2] tx passive, [1] bus-off, [0] overrun |
| errIrq | output | 1 | Combined error interrupt |

## Verification
Counter changes, overrun pulses, clears and soft reset all act through a single flag register. Their effect on flags therefore appears one clock edge after the inputs are applied. The bench drives each stimulus just after an edge and samples one time unit after the next edge. errIrq is combinational from the flag register and the mask, so a mask change shows in that same sample. A recessive sample completes a run at its edge. The first clear that can succeed is therefore issued one cycle after the 128th run ends, and the bench checks the flag after that clear's edge.

// File: rtl/canErrPkg.sv
package canErrPkg;
  localparam int NFLAG    = 4;
  localparam int FLG_OVR  = 0;
  localparam int FLG_BOFF = 1;
  localparam int FLG_TXP  = 2;
  localparam int FLG_RXP  = 3;

  typedef struct packed {
    logic [NFLAG-1:0] setB;
    logic [NFLAG-1:0] clrB;
  } flagStrobes_t;
endpackage

// File: rtl/canBusOffRecovery.sv
module canBusOffRecovery #(
  parameter int RUN_BITS   = 11,
  parameter int RUN_TARGET = 128
) (
  input  logic clk,
  input  logic rstN,
  input  logic restart,
  input  logic sampleStb,
  input  logic busLevel,
  output logic seqDone
);
  localparam int RUN_W = $clog2(RUN_BITS);
  localparam int SEQ_W = $clog2(RUN_TARGET + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_BITS - 1);
  localparam logic [SEQ_W-1:0] SEQ_MAX  = SEQ_W'(RUN_TARGET);

  logic [RUN_W-1:0] runLen;
  logic [SEQ_W-1:0] seqCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen <= '0;
      seqCnt <= '0;
    end else if (restart) begin
      runLen <= '0;
      seqCnt <= '0;
    end else if (sampleStb) begin
      if (!busLevel) begin
        runLen <= '0;
      end else if (runLen == RUN_LAST) begin
        runLen <= '0;
        if (seqCnt != SEQ_MAX) seqCnt <= seqCnt + 1'b1;
      end else begin
        runLen <= runLen + 1'b1;
      end
    end
  end

  assign seqDone = (seqCnt == SEQ_MAX);
endmodule

// File: rtl/canErrCtrl.sv
module canErrCtrl
  import canErrPkg::*;
#(
  parameter int RX_W        = 8,
  parameter int TX_W        = 9,
  parameter int PASSIVE_LVL = 128,
  parameter int BUSOFF_LVL  = 256
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 softRst,
  input  logic [RX_W-1:0]      rxErrCnt,
  input  logic [TX_W-1:0]      txErrCnt,
  input  logic                 overrunEvt,
  input  logic                 clrWe,
  input  logic [NFLAG-1:0]     clrBits,
  input  logic [NFLAG-1:0]     flagsQ,
  input  logic                 seqDone,
  output flagStrobes_t         strobes,
  output logic                 recRestart
);
  localparam logic [RX_W-1:0] RX_LVL   = RX_W'(PASSIVE_LVL);
  localparam logic [TX_W-1:0] TX_LVL   = TX_W'(PASSIVE_LVL);
  localparam logic [TX_W-1:0] TX_BOFF  = TX_W'(BUSOFF_LVL);

  logic rxCond, txCond, boffCond;
  logic rxPrev, txPrev, boffPrev;
  logic boffHeld;

  assign rxCond   = (rxErrCnt >= RX_LVL);
  assign txCond   = (txErrCnt >= TX_LVL) && (txErrCnt < TX_BOFF);
  assign boffCond = (txErrCnt >= TX_BOFF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPrev   <= 1'b0;
      txPrev   <= 1'b0;
      boffPrev <= 1'b0;
    end else begin
      rxPrev   <= rxCond;
      txPrev   <= txCond;
      boffPrev <= boffCond;
    end
  end

  always_comb begin
    strobes = '0;
    strobes.setB[FLG_OVR]  = overrunEvt;
    strobes.setB[FLG_BOFF] = boffCond && !boffPrev;
    boffHeld = flagsQ[FLG_BOFF] || strobes.setB[FLG_BOFF];
    strobes.setB[FLG_TXP]  = txCond && !txPrev && !boffHeld;
    strobes.setB[FLG_RXP]  = rxCond && !rxPrev && !boffHeld;
    for (int i = 0; i < NFLAG; i++) begin
      strobes.clrB[i] = clrWe && clrBits[i] && !strobes.setB[i];
    end
    strobes.clrB[FLG_BOFF] = strobes.clrB[FLG_BOFF] && seqDone;
  end

  assign recRestart = softRst || strobes.setB[FLG_BOFF];
endmodule

// File: rtl/canErrFlagRegs.sv
module canErrFlagRegs
  import canErrPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             softRst,
  input  flagStrobes_t     strobes,
  input  logic [NFLAG-1:0] maskBits,
  output logic [NFLAG-1:0] flagsQ,
  output logic             errIrq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        flagsQ <= '0;
    else if (softRst) flagsQ <= '0;
    else              flagsQ <= (flagsQ & ~strobes.clrB) | strobes.setB;
  end

  assign errIrq = |(flagsQ & ~maskBits);
endmodule

// File: rtl/canErrFlags.sv
module canErrFlags
  import canErrPkg::*;
#(
  parameter int RX_W        = 8,
  parameter int TX_W        = 9,
  parameter int PASSIVE_LVL = 128,
  parameter int BUSOFF_LVL  = 256,
  parameter int RUN_BITS    = 11,
  parameter int RUN_TARGET  = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softRst,
  input  logic [RX_W-1:0]  rxErrCnt,
  input  logic [TX_W-1:0]  txErrCnt,
  input  logic             busLevel,
  input  logic             sampleStb,
  input  logic             overrunEvt,
  input  logic [NFLAG-1:0] maskBits,
  input  logic             clrWe,
  input  logic [NFLAG-1:0] clrBits,
  output logic [NFLAG-1:0] flags,
  output logic             errIrq
);
  flagStrobes_t strobes;
  logic         seqDone;
  logic         recRestart;

  canBusOffRecovery #(.RUN_BITS(RUN_BITS), .RUN_TARGET(RUN_TARGET)) u_rec (
    .clk(clk), .rstN(rstN), .restart(recRestart),
    .sampleStb(sampleStb), .busLevel(busLevel), .seqDone(seqDone)
  );

  canErrCtrl #(.RX_W(RX_W), .TX_W(TX_W), .PASSIVE_LVL(PASSIVE_LVL),
               .BUSOFF_LVL(BUSOFF_LVL)) u_ctrl (
    .clk(clk), .rstN(rstN), .softRst(softRst), .rxErrCnt(rxErrCnt),
    .txErrCnt(txErrCnt), .overrunEvt(overrunEvt), .clrWe(clrWe),
    .clrBits(clrBits), .flagsQ(flags), .seqDone(seqDone),
    .strobes(strobes), .recRestart(recRestart)
  );

  canErrFlagRegs u_regs (
    .clk(clk), .rstN(rstN), .softRst(softRst), .strobes(strobes),
    .maskBits(maskBits), .flagsQ(flags), .errIrq(errIrq)
  );
endmodule

// File: rtl/canErrFlagsChk.sv
module canErrFlagsChk #(
  parameter int RX_W        = 8,
  parameter int TX_W        = 9,
  parameter int PASSIVE_LVL = 128,
  parameter int BUSOFF_LVL  = 256
) (
  input logic            clk,
  input logic            rstN,
  input logic            softRst,
  input logic [RX_W-1:0] rxErrCnt,
  input logic [TX_W-1:0] txErrCnt,
  input logic            overrunEvt,
  input logic [3:0]      maskBits,
  input logic [3:0]      flags,
  input logic            errIrq,
  input logic            seqDone
);
  localparam logic [RX_W-1:0] RX_LVL  = RX_W'(PASSIVE_LVL);
  localparam logic [TX_W-1:0] TX_LVL  = TX_W'(PASSIVE_LVL);
  localparam logic [TX_W-1:0] TX_BOFF = TX_W'(BUSOFF_LVL);

  assert_rx_band_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[3]) |-> ($past(rxErrCnt) >= RX_LVL));
  assert_tx_band_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[2]) |-> ($past(txErrCnt) >= TX_LVL && $past(txErrCnt) < TX_BOFF));
  assert_boff_entry_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[1]) |-> ($past(txErrCnt) >= TX_BOFF));
  assert_passive_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(flags[2]) || $rose(flags[3])) |-> !$past(flags[1]));
  assert_boff_locked_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(flags[1]) && !$past(softRst)) |-> $past(seqDone));
  assert_ovr_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (overrunEvt && !softRst) |=> flags[0]);
  assert_irq_on_R9: assert property (@(posedge clk) disable iff (!rstN)
    (flags[0] && !maskBits[0]) |-> errIrq);
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (maskBits == 4'hF) |-> !errIrq);
  assert_softrst_R10: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (flags == 4'h0));
endmodule

bind canErrFlags canErrFlagsChk #(
  .RX_W(RX_W), .TX_W(TX_W), .PASSIVE_LVL(PASSIVE_LVL), .BUSOFF_LVL(BUSOFF_LVL)
) u_chk (
  .clk(clk), .rstN(rstN), .softRst(softRst), .rxErrCnt(rxErrCnt),
  .txErrCnt(txErrCnt), .overrunEvt(overrunEvt), .maskBits(maskBits),
  .flags(flags), .errIrq(errIrq), .seqDone(seqDone)
);

// File: tb/canErrFlags_tb.sv
module canErrFlags_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  typedef struct packed {
    logic [7:0] rx;
    logic [8:0] tx;
    logic       ovr;
    logic       cw;
    logic [3:0] cb;
    logic [3:0] mk;
    logic [3:0] ef;
    logic       ei;
    logic [3:0] req;
  } vec_t;

  // fields: rx, tx, ovr, clrWe, clrBits, mask, expFlags, expIrq, requirement
  localparam vec_t VECS [NVEC] = '{
    '{8'd0,   9'd0,   1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 1'b0, 4'd9},  // R9 idle
    '{8'd130, 9'd0,   1'b0, 1'b0, 4'h0, 4'h0, 4'h8, 1'b1, 4'd1},  // R1 rx passive
    '{8'd130, 9'd0,   1'b0, 1'b0, 4'h0, 4'h8, 4'h8, 1'b0, 4'd9},  // R9 masked
    '{8'd130, 9'd0,   1'b0, 1'b1, 4'h8, 4'h0, 4'h0, 1'b0, 4'd8},  // R8 clear
    '{8'd130, 9'd0,   1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 1'b0, 4'd8},  // R8 no re-set
    '{8'd100, 9'd200, 1'b0, 1'b0, 4'h0, 4'h0, 4'h4, 1'b1, 4'd2},  // R2 tx passive
    '{8'd100, 9'd200, 1'b1, 1'b0, 4'h0, 4'h0, 4'h5, 1'b1, 4'd7},  // R7 overrun
    '{8'd100, 9'd200, 1'b1, 1'b1, 4'h1, 4'h0, 4'h5, 1'b1, 4'd8},  // R8 set wins
    '{8'd100, 9'd200, 1'b0, 1'b1, 4'h5, 4'h0, 4'h0, 1'b0, 4'd8},  // R8 clear two
    '{8'd100, 9'd300, 1'b0, 1'b0, 4'h0, 4'h0, 4'h2, 1'b1, 4'd3},  // R3 bus-off
    '{8'd200, 9'd200, 1'b0, 1'b0, 4'h0, 4'h0, 4'h2, 1'b1, 4'd4},  // R4 suppressed
    '{8'd200, 9'd200, 1'b0, 1'b1, 4'h2, 4'h0, 4'h2, 1'b1, 4'd5}   // R5 locked
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       softRst = 1'b0;
  logic [7:0] rxErrCnt = '0;
  logic [8:0] txErrCnt = '0;
  logic       busLevel = 1'b1;
  logic       sampleStb = 1'b0;
  logic       overrunEvt = 1'b0;
  logic [3:0] maskBits = '0;
  logic       clrWe = 1'b0;
  logic [3:0] clrBits = '0;
  logic [3:0] flags;
  logic       errIrq;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  canErrFlags u_dut (
    .clk(clk), .rstN(rstN), .softRst(softRst), .rxErrCnt(rxErrCnt),
    .txErrCnt(txErrCnt), .busLevel(busLevel), .sampleStb(sampleStb),
    .overrunEvt(overrunEvt), .maskBits(maskBits), .clrWe(clrWe),
    .clrBits(clrBits), .flags(flags), .errIrq(errIrq)
  );

  task automatic check(input logic [3:0] ef, input logic ei, input string req);
    nRun++;
    if (flags !== ef || errIrq !== ei) begin
      nFail++;
      $display("FAIL %s: flags=%h irq=%b expected flags=%h irq=%b", req, flags, errIrq, ef, ei);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic sendBits(input int n, input logic lvl);
    for (int i = 0; i < n; i++) begin
      sampleStb = 1'b1;
      busLevel  = lvl;
      tick();
    end
    sampleStb = 1'b0;
    busLevel  = 1'b1;
  endtask

  task automatic clearPulse(input logic [3:0] bits);
    clrWe = 1'b1;
    clrBits = bits;
    tick();
    clrWe = 1'b0;
    clrBits = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(4'h0, 1'b0, "R11 reset");
    rstN = 1'b1;
    tick();
    check(4'h0, 1'b0, "R11 after release");

    for (int v = 0; v < NVEC; v++) begin
      rxErrCnt   = VECS[v].rx;
      txErrCnt   = VECS[v].tx;
      overrunEvt = VECS[v].ovr;
      clrWe      = VECS[v].cw;
      clrBits    = VECS[v].cb;
      maskBits   = VECS[v].mk;
      tick();
      check(VECS[v].ef, VECS[v].ei, $sformatf("R%0d vector %0d", VECS[v].req, v));
    end
    overrunEvt = 1'b0;
    clrWe = 1'b0;
    clrBits = '0;

    // R5: 127 full runs, then a run broken by a dominant sample
    sendBits(127 * 11, 1'b1);
    sendBits(10, 1'b1);
    sendBits(1, 1'b0);
    clearPulse(4'h2);
    check(4'h2, 1'b1, "R5 clear blocked after 127 runs and a broken run");
    sendBits(11, 1'b1);
    clearPulse(4'h2);
    check(4'h0, 1'b0, "R5 clear accepted after 128 runs");

    // R6: re-entering bus-off restarts the run count
    txErrCnt = 9'd300;
    tick();
    check(4'h2, 1'b1, "R6 bus-off re-entered");
    clearPulse(4'h2);
    check(4'h2, 1'b1, "R6 clear blocked after restart");

    // R10: soft reset clears and blocks setting
    softRst = 1'b1;
    overrunEvt = 1'b1;
    tick();
    check(4'h0, 1'b0, "R10 soft reset clears flags");
    tick();
    check(4'h0, 1'b0, "R10 overrun ignored in soft reset");
    softRst = 1'b0;
    overrunEvt = 1'b0;
    tick();
    check(4'h0, 1'b0, "R10 released, nothing pending");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule